// File: doc/BRIEF.md
# Serial-Loaded Sixteen-Channel LED PWM Core

This block is the digital heart of a sixteen-channel LED driver. A single serial port fills one of two shift registers. One holds a 12-bit brightness word for each channel, and the other holds a 6-bit current-trim word for each channel. A select input chooses the target register. A strobe copies the chosen shift register into its own holding latch. The serial output always shows the top bit of the chosen shift register, so several devices can be chained in a loop.

A free-running brightness counter advances on a separate reference clock. Each channel enable stays on while the count is below that channel's latched brightness word. The counter stops at its top value, so one pass of the reference clock gives one PWM period. A blanking input forces every channel off and returns the counter to zero, which starts the next period. The current-trim words are only stored and exposed on a port for the analog section. An active-low fault output combines two fault inputs.

All serial, strobe and reference clock inputs are treated as level signals in the system clock domain, and the block acts on their rising edges.

Top module: `led_pwm_core`

## Requirements
- R1: With `sel_trim` low, serial clock edges, strobes and `ser_out` act only on the brightness shift register and latch. With `sel_trim` high, they act only on the trim shift register and latch. The register that is not selected keeps its contents.
- R2: Each rising edge of `ser_clk` shifts the selected register one place toward its top bit, and `ser_in` enters at bit 0. `ser_out` equals the top bit of the selected shift register.
- R3: A rising edge of `latch_stb` copies the selected shift register into its latch. Without that edge, both latches hold their contents whatever happens on the serial port.
- R4: While `blank` is low, each rising edge of `ref_clk` raises the brightness count by one.
- R5: While `blank` is high, all sixteen bits of `ch_on` are 0 and the count is held at 0.
- R6: When `blank` is low, `ch_on[n]` is 1 exactly when the count is less than channel n's latched brightness word. A word of 0 keeps the channel off for the whole period.
- R7: The count stops at 4095 and does not wrap, so all channels stay off until `blank` is pulsed.
- R8: `fault_n` is 0 when `open_fault` or `hot_fault` is 1, and is 1 otherwise.
- R9: Asynchronous reset clears both shift registers, both latches and the count. After reset, `ch_on`, `trim_out` and `ser_out` are 0.
- R10: `sel_trim` must not change while `ser_clk` is high. This is a protocol rule on the environment.
- R11: In the brightness register, channel n occupies bits [12n+11:12n], so channel 15 sits at the top end. In the trim register and on `trim_out`, channel n occupies bits [6n+5:6n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data in |
| ser_clk | input | 1 | Serial shift clock (level, edge-detected) |
| latch_stb | input | 1 | Latch strobe (level, edge-detected) |
| sel_trim | input | 1 | 0 selects the brightness register, 1 selects the trim register |
| ref_clk | input | 1 | PWM reference clock (level, edge-detected) |
| blank | input | 1 | Forces all channels off and clears the count |
| open_fault | input | 1 | Open-LED fault flag |
| hot_fault | input | 1 | Over-temperature fault flag |
| ser_out | output | 1 | Top bit of the selected shift register |
| ch_on | output | 16 | Channel enables |
| trim_out | output | 96 | Latched trim words |
| fault_n | output | 1 | Active-low fault indication |

## Verification
A fault in either shift register reaches `ser_out` only after the bad bit has been shifted up to the top. The bench therefore shifts out a whole channel word and compares it bit by bit. A bad latch or a wrong field position appears on `ch_on` or `trim_out` in the first cycle after the strobe, because the bench checks the enables against the count after every single reference clock edge. A counter that wraps, skips or misses a blank shows up as a wrong enable pattern within one reference edge. The final edges past 4095 expose a counter that fails to saturate.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
    localparam int NUM_CH   = 16;
    localparam int GS_BITS  = 12;
    localparam int DC_BITS  = 6;
    localparam int GS_WIDTH = NUM_CH * GS_BITS;
    localparam int DC_WIDTH = NUM_CH * DC_BITS;
    // indices into the edge-detector vector
    localparam int EDGE_SER = 0;
    localparam int EDGE_LAT = 1;
    localparam int EDGE_REF = 2;
    localparam int EDGE_NUM = 3;
endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rise_o    = level_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/shift_latch.sv
module shift_latch #(
    parameter int WIDTH = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             load_en,
    input  logic             sin,
    output logic             sout,
    output logic [WIDTH-1:0] held_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
        logic [WIDTH-1:0] held;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.sr   = {st_q.sr[WIDTH-2:0], sin};
        if (load_en)  st_d.held = st_q.sr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sout   = st_q.sr[WIDTH-1];
    assign held_o = st_q.held;

    // R2: the new bit 0 is the serial input sampled on the shift edge
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.sr[0] == $past(sin));
    // R3: the latch only changes on a load
    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(st_q.held));
    // R1: a register that is not shifting keeps its contents
    assert_sr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.sr));
endmodule

// File: rtl/gs_counter.sv
module gs_counter #(
    parameter int BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blank,
    input  logic            step,
    output logic [BITS-1:0] cnt_o,
    output logic            at_max_o
);
    localparam logic [BITS-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [BITS-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (blank)                            st_d.cnt = '0;
        else if (step && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign at_max_o = (st_q.cnt == CNT_MAX);

    assert_blank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> st_q.cnt == '0);
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && st_q.cnt == CNT_MAX) |=> st_q.cnt == CNT_MAX);
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && !step) |=> $stable(st_q.cnt));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int NUM_CH = 16,
    parameter int BITS   = 12
) (
    input  logic                   blank,
    input  logic [BITS-1:0]        cnt,
    input  logic [NUM_CH*BITS-1:0] level_words,
    output logic [NUM_CH-1:0]      ch_on
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [BITS-1:0] word;
        assign word     = level_words[n*BITS +: BITS];
        assign ch_on[n] = !blank && (cnt < word);
        // R6: a zero word never lights the channel
        always_comb begin
            if (word == '0) assert_zero_off_R6: assert (!ch_on[n]);
        end
    end
endmodule

// File: rtl/led_pwm_core.sv
module led_pwm_core
    import led_pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                ser_clk,
    input  logic                latch_stb,
    input  logic                sel_trim,
    input  logic                ref_clk,
    input  logic                blank,
    input  logic                open_fault,
    input  logic                hot_fault,
    output logic                ser_out,
    output logic [NUM_CH-1:0]   ch_on,
    output logic [DC_WIDTH-1:0] trim_out,
    output logic                fault_n
);
    logic [EDGE_NUM-1:0] rise;
    logic                gs_sout, dc_sout;
    logic [GS_WIDTH-1:0] gs_held;
    logic [GS_BITS-1:0]  cnt;
    logic                cnt_max;

    rise_detect #(.N(EDGE_NUM)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({ref_clk, latch_stb, ser_clk}),
        .rise_o  (rise)
    );

    shift_latch #(.WIDTH(GS_WIDTH)) u_gs (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rise[EDGE_SER] && !sel_trim),
        .load_en  (rise[EDGE_LAT] && !sel_trim),
        .sin      (ser_in),
        .sout     (gs_sout),
        .held_o   (gs_held)
    );

    shift_latch #(.WIDTH(DC_WIDTH)) u_dc (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rise[EDGE_SER] && sel_trim),
        .load_en  (rise[EDGE_LAT] && sel_trim),
        .sin      (ser_in),
        .sout     (dc_sout),
        .held_o   (trim_out)
    );

    gs_counter #(.BITS(GS_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank    (blank),
        .step     (rise[EDGE_REF]),
        .cnt_o    (cnt),
        .at_max_o (cnt_max)
    );

    pwm_compare #(.NUM_CH(NUM_CH), .BITS(GS_BITS)) u_cmp (
        .blank       (blank),
        .cnt         (cnt),
        .level_words (gs_held),
        .ch_on       (ch_on)
    );

    assign ser_out = sel_trim ? dc_sout : gs_sout;
    assign fault_n = !(open_fault || hot_fault);

    // R10: protocol rule on the environment
    assert_sel_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(sel_trim));
    // R7: at the saturated count no channel is lit
    assert_max_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_max |-> ch_on == '0);
    // R5: a blank held across two cycles leaves every channel dark
    assert_blank_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && $past(blank)) |-> ch_on == '0);
endmodule

// File: tb/sim_led_pwm_core.sv
module sim_led_pwm_core;
    localparam int CLK_P = 10;
    localparam int NCH = 16;
    localparam int GSW = 192;
    localparam int DCW = 96;

    logic clk = 0, rst_n = 0;
    logic ser_in = 0, ser_clk = 0, latch_stb = 0, sel_trim = 0;
    logic ref_clk = 0, blank = 1, open_fault = 0, hot_fault = 0;
    logic ser_out, fault_n;
    logic [NCH-1:0] ch_on;
    logic [DCW-1:0] trim_out;

    int n_tests = 0, n_fail = 0;
    logic [GSW-1:0] gs_vec;
    logic [DCW-1:0] dc_vec;

    led_pwm_core u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_clk(ser_clk),
        .latch_stb(latch_stb), .sel_trim(sel_trim), .ref_clk(ref_clk),
        .blank(blank), .open_fault(open_fault), .hot_fault(hot_fault),
        .ser_out(ser_out), .ch_on(ch_on), .trim_out(trim_out), .fault_n(fault_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string req, logic [DCW-1:0] act, logic [DCW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic shift_bit(logic b);
        ser_in = b; ser_clk = 1; tick();
        ser_clk = 0; tick();
    endtask

    task automatic strobe();
        latch_stb = 1; tick();
        latch_stb = 0; tick();
    endtask

    task automatic ref_pulse();
        ref_clk = 1; tick();
        ref_clk = 0; tick();
    endtask

    function automatic logic [11:0] gs_word(int n);
        return (n == 15) ? 12'd4095 : 12'(n * 260);
    endfunction

    function automatic logic [NCH-1:0] expect_on(int cnt);
        logic [NCH-1:0] e;
        for (int n = 0; n < NCH; n++) e[n] = (cnt < int'(gs_word(n)));
        return e;
    endfunction

    task automatic t_reset();
        check("R9 ch_on", DCW'(ch_on), '0);
        check("R9 trim_out", trim_out, '0);
        check("R9 ser_out", DCW'(ser_out), '0);
    endtask

    task automatic t_fault();
        for (int i = 0; i < 4; i++) begin
            open_fault = i[0]; hot_fault = i[1]; #1;
            check("R8 fault_n", DCW'(fault_n), DCW'(i == 0));
        end
        open_fault = 0; hot_fault = 0;
    endtask

    task automatic t_load_gs();
        for (int n = 0; n < NCH; n++) gs_vec[n*12 +: 12] = gs_word(n);
        sel_trim = 0; blank = 0;
        for (int i = GSW - 1; i >= 0; i--) shift_bit(gs_vec[i]);
        check("R2 ser_out top bit", DCW'(ser_out), DCW'(gs_vec[GSW-1]));
        check("R3 no strobe, channels dark", DCW'(ch_on), '0);
        strobe();
        check("R3 R11 after strobe", DCW'(ch_on), DCW'(expect_on(0)));
    endtask

    task automatic t_pwm();
        logic [NCH-1:0] hold;
        for (int k = 1; k <= 4097; k++) begin
            ref_pulse();
            check("R4 R6 R7 ch_on vs count", DCW'(ch_on), DCW'(expect_on(k > 4095 ? 4095 : k)));
        end
        blank = 1; tick();
        check("R5 blank dark", DCW'(ch_on), '0);
        ref_pulse();
        check("R5 ref ignored in blank", DCW'(ch_on), '0);
        blank = 0; #1;
        hold = expect_on(0);
        check("R5 count restarted", DCW'(ch_on), DCW'(hold));
        ref_pulse(); ref_pulse();
        check("R4 two steps", DCW'(ch_on), DCW'(expect_on(2)));
        blank = 1; tick(); blank = 0; tick();
    endtask

    task automatic t_load_dc();
        for (int n = 0; n < NCH; n++) dc_vec[n*6 +: 6] = 6'((n * 5 + 3) % 64);
        sel_trim = 1; tick();
        for (int i = DCW - 1; i >= 0; i--) shift_bit(dc_vec[i]);
        check("R1 trim not latched yet", trim_out, '0);
        check("R2 trim ser_out", DCW'(ser_out), DCW'(dc_vec[DCW-1]));
        strobe();
        check("R11 trim_out fields", trim_out, dc_vec);
        check("R1 brightness latch kept", DCW'(ch_on), DCW'(expect_on(0)));
        sel_trim = 0; tick();
        check("R1 brightness register kept", DCW'(ser_out), DCW'(gs_vec[GSW-1]));
    endtask

    task automatic t_shift_out();
        logic [11:0] got;
        sel_trim = 0; tick();
        for (int b = 11; b >= 0; b--) begin
            got[b] = ser_out;
            shift_bit(1'b0);
        end
        check("R2 R11 channel 15 shifted out", DCW'(got), DCW'(gs_word(15)));
        check("R3 latch held while shifting", DCW'(ch_on), DCW'(expect_on(0)));
        sel_trim = 1; tick();
        check("R1 trim latch kept", trim_out, dc_vec);
        for (int i = 0; i < 6; i++) shift_bit(1'b1);
        strobe();
        check("R3 trim relatched", trim_out, {dc_vec[DCW-7:0], 6'h3f});
        sel_trim = 0; tick();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1; tick();
        t_fault();
        t_load_gs();
        t_pwm();
        t_load_dc();
        t_shift_out();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule